// File: doc/BRIEF.md
# Operand Addressing Mode Unit

This block fetches one operand for a small four-register machine. A request carries a 3-bit mode, a register number and a 16-bit constant. The unit works out the effective address, issues the memory reads the mode needs, returns the operand value and applies any register side effect the mode implies. It owns the register file. A separate write port lets the execution stage write results back into that file.

Requests enter on a valid/ready pair. `req_ready` is high only while the unit is idle, and the request fields are captured on the cycle where `req_valid` and `req_ready` are both high. Memory reads leave on a valid/ready pair. Once raised, `mem_rd_valid` stays high and `mem_rd_addr` stays unchanged until `mem_rd_ready` is seen. The unit then waits for one `mem_rsp_valid` pulse carrying the word, and it accepts that response in any cycle. The result leaves on a valid/ready pair. `res_valid` and `res_data` hold until `res_ready`, so a stalled consumer stops the unit without losing the operand. The memory is word-addressed, and every address calculation wraps modulo 2^16.

Top module: `opnd_fetch`

## Requirements
- R1: After reset `req_ready`=1, `res_valid`=0 and `mem_rd_valid`=0, and all four registers read as zero.
- R2: Mode encoding 0 is immediate. The result is the request constant, and no memory read is issued.
- R3: Mode 1 is register. The result is the content of the named register, and no memory read is issued.
- R4: Mode 2 is absolute. The unit makes exactly one read, at the constant, and returns that word.
- R5: Mode 3 is register-indirect. The unit makes exactly one read, at the address held in the named register.
- R6: Mode 4 is memory-indirect. The unit makes two reads. The first is at the constant. The second is at the word the first read returned, and its data is the result.
- R7: Mode 5 is indexed. The unit makes one read, at register plus constant, modulo 2^16.
- R8: Mode 6 is autoincrement. The unit reads at the register value. On the cycle the result is taken, the register becomes its value plus 1, modulo 2^16.
- R9: Mode 7 is autodecrement. The unit reads at the register value minus 1, and the register takes that decremented value when the result is taken.
- R10: While `mem_rd_ready` is low, `mem_rd_valid` stays high and `mem_rd_addr` is unchanged.
- R11: While `res_ready` is low, `res_valid` and `res_data` hold and `req_ready` stays low. After the result is taken, `req_ready` returns to 1.
- R12: `wr_en` writes `wr_data` into register `wr_sel` at the clock edge. If a side-effect update targets the same register in the same cycle, the write port wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Unit idle, request accepted |
| req_mode | input | 3 | Addressing mode (0..7) |
| req_reg | input | 2 | Register number |
| req_const | input | 16 | Immediate value, address or offset |
| res_valid | output | 1 | Operand available |
| res_ready | input | 1 | Consumer takes the operand |
| res_data | output | 16 | Operand value |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the request |
| mem_rd_addr | output | 16 | Word address of the read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 16 | Read data |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | Register written |
| wr_data | input | 16 | Value written |

## Verification
A corrupted latched address appears on `mem_rd_addr` in the first request cycle after the fault. A memory-indirect fault shows on the second request, two handshakes after acceptance. A wrong side-effect value stays hidden until a later register-mode fetch reads that register back, so each autoincrement and autodecrement test ends with such a fetch. A wrong read count shows up in the bench log of memory handshakes before `res_valid` rises. A broken hold on a stalled port shows within one cycle of the stall.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  typedef enum logic [2:0] {
    M_IMM  = 3'd0,
    M_REG  = 3'd1,
    M_ABS  = 3'd2,
    M_RIND = 3'd3,
    M_MIND = 3'd4,
    M_IDX  = 3'd5,
    M_AINC = 3'd6,
    M_ADEC = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_RREQ  = 2'd1,
    S_RWAIT = 2'd2,
    S_DONE  = 2'd3
  } fstate_e;
endpackage

// File: rtl/opnd_regs.sv
module opnd_regs #(
  parameter int DW   = 16,
  parameter int NREG = 4,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          upd_en,
  input  logic [RW-1:0] upd_sel,
  input  logic [DW-1:0] upd_data
);
  logic [DW-1:0] regs [NREG];

  assign rd_data = regs[rd_sel];

  // external write port has priority over the addressing side effect
  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n)                            regs[i] <= '0;
      else if (wr_en && wr_sel == RW'(i))    regs[i] <= wr_data;
      else if (upd_en && upd_sel == RW'(i))  regs[i] <= upd_data;
    end
  end

  assert_upd_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !(wr_en && wr_sel == upd_sel)) |=> regs[$past(upd_sel)] == $past(upd_data));

  assert_wr_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/opnd_ea.sv
module opnd_ea
  import opnd_pkg::*;
#(
  parameter int DW = 16
) (
  input  amode_e        mode,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] cnst,
  output logic [DW-1:0] ea,
  output logic [1:0]    reads,
  output logic          upd_en,
  output logic [DW-1:0] upd_val
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] base_inc, base_dec;
  assign base_inc = base + ONE;
  assign base_dec = base - ONE;

  always_comb begin
    ea      = cnst;
    reads   = 2'd0;
    upd_en  = 1'b0;
    upd_val = base;
    unique case (mode)
      M_IMM:  reads = 2'd0;
      M_REG:  reads = 2'd0;
      M_ABS:  reads = 2'd1;
      M_RIND: begin ea = base; reads = 2'd1; end
      M_MIND: reads = 2'd2;
      M_IDX:  begin ea = base + cnst; reads = 2'd1; end
      M_AINC: begin ea = base; reads = 2'd1; upd_en = 1'b1; upd_val = base_inc; end
      M_ADEC: begin ea = base_dec; reads = 2'd1; upd_en = 1'b1; upd_val = base_dec; end
      default: reads = 2'd0;
    endcase
  end
endmodule

// File: rtl/opnd_seq.sv
module opnd_seq
  import opnd_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 4,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  amode_e        mode,
  input  logic [RW-1:0] reg_in,
  input  logic [DW-1:0] cnst,
  input  logic [DW-1:0] regval,
  input  logic [DW-1:0] ea,
  input  logic [1:0]    reads,
  input  logic          upd_req,
  input  logic [DW-1:0] upd_val,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [DW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data,
  output logic          upd_en,
  output logic [RW-1:0] upd_sel,
  output logic [DW-1:0] upd_data
);
  fstate_e       st_q;
  amode_e        mode_q;
  logic [1:0]    left_q;
  logic [DW-1:0] addr_q, data_q, updv_q;
  logic [RW-1:0] sel_q;
  logic          updp_q;

  assign req_ready    = (st_q == S_IDLE);
  assign mem_rd_valid = (st_q == S_RREQ);
  assign mem_rd_addr  = addr_q;
  assign res_valid    = (st_q == S_DONE);
  assign res_data     = data_q;
  assign upd_en       = (st_q == S_DONE) && res_ready && updp_q;
  assign upd_sel      = sel_q;
  assign upd_data     = updv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      mode_q <= M_IMM;
      left_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      updv_q <= '0;
      sel_q  <= '0;
      updp_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_valid) begin
          mode_q <= mode;
          sel_q  <= reg_in;
          updp_q <= upd_req;
          updv_q <= upd_val;
          addr_q <= ea;
          left_q <= reads;
          if (reads == 2'd0) begin
            data_q <= (mode == M_IMM) ? cnst : regval;
            st_q   <= S_DONE;
          end else begin
            st_q   <= S_RREQ;
          end
        end
        S_RREQ: if (mem_rd_ready) st_q <= S_RWAIT;
        S_RWAIT: if (mem_rsp_valid) begin
          if (left_q == 2'd2) begin
            addr_q <= mem_rsp_data;
            left_q <= 2'd1;
            st_q   <= S_RREQ;
          end else begin
            data_q <= mem_rsp_data;
            st_q   <= S_DONE;
          end
        end
        S_DONE: if (res_ready) begin
          updp_q <= 1'b0;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  assert_res_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  assert_ready_back_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> req_ready);

  assert_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != S_IDLE) && (mode_q == M_IMM || mode_q == M_REG)) |-> !mem_rd_valid);
endmodule

// File: rtl/opnd_fetch.sv
module opnd_fetch
  import opnd_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 4,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_mode,
  input  logic [RW-1:0] req_reg,
  input  logic [DW-1:0] req_const,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [DW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data
);
  amode_e        mode;
  logic [DW-1:0] regval, ea, upd_val, upd_data;
  logic [1:0]    reads;
  logic          upd_req, upd_en;
  logic [RW-1:0] upd_sel;

  assign mode = amode_e'(req_mode);

  opnd_regs #(.DW(DW), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .rd_sel(req_reg), .rd_data(regval),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .upd_en(upd_en), .upd_sel(upd_sel), .upd_data(upd_data)
  );

  opnd_ea #(.DW(DW)) u_ea (
    .mode(mode), .base(regval), .cnst(req_const),
    .ea(ea), .reads(reads), .upd_en(upd_req), .upd_val(upd_val)
  );

  opnd_seq #(.DW(DW), .NREG(NREG)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .mode(mode), .reg_in(req_reg), .cnst(req_const), .regval(regval),
    .ea(ea), .reads(reads), .upd_req(upd_req), .upd_val(upd_val),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .upd_en(upd_en), .upd_sel(upd_sel), .upd_data(upd_data)
  );
endmodule

// File: tb/opnd_fetch_bench.sv
`timescale 1ns/1ps
module opnd_fetch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, res_ready = 1'b0;
  logic [2:0]  req_mode = '0;
  logic [1:0]  req_reg = '0;
  logic [15:0] req_const = '0;
  logic        req_ready, res_valid, mem_rd_valid;
  logic [15:0] res_data, mem_rd_addr;
  logic        mem_rd_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;

  int total = 0, bad = 0;
  int stall = 0;
  int rd_cnt = 0;
  logic [15:0] rd_addr [4];

  always #2.5 clk = ~clk;

  opnd_fetch u_opnd_fetch (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_reg(req_reg), .req_const(req_const),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data)
  );

  function automatic logic [15:0] memf(input logic [15:0] a);
    return a * 16'd3 + 16'd7;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: stalls `stall` cycles, then accepts and answers one cycle later
  initial begin
    bit          pend = 0;
    logic [15:0] paddr = '0, held = '0;
    int          w = 0;
    forever begin
      @(negedge clk);
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = memf(paddr);
        pend = 0;
      end else begin
        mem_rsp_valid = 1'b0;
      end
      if (mem_rd_valid) begin
        if (w > 0) check("R10 addr hold", mem_rd_addr, held);
        held = mem_rd_addr;
        if (w < stall) begin
          mem_rd_ready = 1'b0;
          w++;
        end else begin
          mem_rd_ready = 1'b1;
          if (rd_cnt < 4) rd_addr[rd_cnt] = mem_rd_addr;
          rd_cnt++;
          pend  = 1;
          paddr = mem_rd_addr;
          w = 0;
        end
      end else begin
        if (w > 0) begin
          total++; bad++;
          $display("FAIL R10 valid dropped during stall actual=0 expected=1");
        end
        mem_rd_ready = 1'b0;
        w = 0;
      end
    end
  end

  task automatic fetch(input logic [2:0] m, input logic [1:0] r, input logic [15:0] c,
                       input int hold, input bit wen, input logic [1:0] wsel,
                       input logic [15:0] wval, output logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_reg = r; req_const = c;
    rd_cnt = 0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    d = res_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R11 res_valid hold", {15'd0, res_valid}, 16'd1);
      check("R11 res_data hold", res_data, d);
      check("R11 req_ready low", {15'd0, req_ready}, 16'd0);
    end
    res_ready = 1'b1;
    wr_en = wen; wr_sel = wsel; wr_data = wval;
    @(negedge clk);
    res_ready = 1'b0; wr_en = 1'b0;
    check("R11 ready back", {15'd0, req_ready}, 16'd1);
  endtask

  task automatic wreg(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] rc16(input int n);
    return 16'(n);
  endfunction

  task automatic t_reset;
    logic [15:0] d;
    check("R1 req_ready", {15'd0, req_ready}, 16'd1);
    check("R1 res_valid", {15'd0, res_valid}, 16'd0);
    check("R1 mem_rd_valid", {15'd0, mem_rd_valid}, 16'd0);
    for (int i = 0; i < 4; i++) begin
      fetch(3'd1, 2'(i), 16'h0, 0, 0, 2'd0, 16'h0, d);
      check("R1 reg zero", d, 16'h0);
    end
  endtask

  task automatic t_write_reg;
    logic [15:0] d;
    wreg(2'd1, 16'h0010);
    wreg(2'd2, 16'hFFFF);
    wreg(2'd3, 16'h0200);
    fetch(3'd1, 2'd1, 16'h0, 0, 0, 2'd0, 16'h0, d); check("R12 write R1", d, 16'h0010);
    fetch(3'd1, 2'd3, 16'h0, 0, 0, 2'd0, 16'h0, d); check("R3 register value", d, 16'h0200);
    check("R3 no read", rc16(rd_cnt), 16'd0);
  endtask

  task automatic t_imm;
    logic [15:0] d;
    fetch(3'd0, 2'd3, 16'd200, 0, 0, 2'd0, 16'h0, d);
    check("R2 immediate", d, 16'd200);
    check("R2 no read", rc16(rd_cnt), 16'd0);
  endtask

  task automatic t_abs;
    logic [15:0] d;
    fetch(3'd2, 2'd1, 16'h0040, 0, 0, 2'd0, 16'h0, d);
    check("R4 data", d, memf(16'h0040));
    check("R4 reads", rc16(rd_cnt), 16'd1);
    check("R4 addr", rd_addr[0], 16'h0040);
  endtask

  task automatic t_rind;
    logic [15:0] d;
    fetch(3'd3, 2'd1, 16'h1234, 0, 0, 2'd0, 16'h0, d);
    check("R5 data", d, memf(16'h0010));
    check("R5 addr", rd_addr[0], 16'h0010);
    check("R5 reads", rc16(rd_cnt), 16'd1);
  endtask

  task automatic t_mind;
    logic [15:0] d;
    fetch(3'd4, 2'd0, 16'h0100, 0, 0, 2'd0, 16'h0, d);
    check("R6 reads", rc16(rd_cnt), 16'd2);
    check("R6 first addr", rd_addr[0], 16'h0100);
    check("R6 second addr", rd_addr[1], memf(16'h0100));
    check("R6 data", d, memf(memf(16'h0100)));
  endtask

  task automatic t_idx;
    logic [15:0] d;
    fetch(3'd5, 2'd3, 16'h0005, 0, 0, 2'd0, 16'h0, d);
    check("R7 addr", rd_addr[0], 16'h0205);
    check("R7 data", d, memf(16'h0205));
    fetch(3'd5, 2'd2, 16'h0002, 0, 0, 2'd0, 16'h0, d);
    check("R7 wrap addr", rd_addr[0], 16'h0001);
  endtask

  task automatic t_ainc;
    logic [15:0] d;
    fetch(3'd6, 2'd2, 16'h0, 0, 0, 2'd0, 16'h0, d);
    check("R8 addr", rd_addr[0], 16'hFFFF);
    check("R8 data", d, memf(16'hFFFF));
    fetch(3'd1, 2'd2, 16'h0, 0, 0, 2'd0, 16'h0, d);
    check("R8 reg wrapped", d, 16'h0000);
    fetch(3'd6, 2'd2, 16'h0, 0, 0, 2'd0, 16'h0, d);
    fetch(3'd1, 2'd2, 16'h0, 0, 0, 2'd0, 16'h0, d);
    check("R8 reg inc", d, 16'h0001);
  endtask

  task automatic t_adec;
    logic [15:0] d;
    fetch(3'd7, 2'd1, 16'h0, 0, 0, 2'd0, 16'h0, d);
    check("R9 addr", rd_addr[0], 16'h000F);
    check("R9 data", d, memf(16'h000F));
    fetch(3'd1, 2'd1, 16'h0, 0, 0, 2'd0, 16'h0, d);
    check("R9 reg dec", d, 16'h000F);
    fetch(3'd7, 2'd0, 16'h0, 0, 0, 2'd0, 16'h0, d);
    check("R9 wrap addr", rd_addr[0], 16'hFFFF);
    fetch(3'd1, 2'd0, 16'h0, 0, 0, 2'd0, 16'h0, d);
    check("R9 reg wrap", d, 16'hFFFF);
  endtask

  task automatic t_stalls;
    logic [15:0] d;
    stall = 3;
    fetch(3'd4, 2'd0, 16'h0300, 2, 0, 2'd0, 16'h0, d);
    check("R10 stalled data", d, memf(memf(16'h0300)));
    check("R10 stalled reads", rc16(rd_cnt), 16'd2);
    stall = 0;
  endtask

  task automatic t_collide;
    logic [15:0] d;
    fetch(3'd6, 2'd1, 16'h0, 1, 1, 2'd1, 16'h0777, d);
    check("R12 collision data", d, memf(16'h000F));
    fetch(3'd1, 2'd1, 16'h0, 0, 0, 2'd0, 16'h0, d);
    check("R12 write wins", d, 16'h0777);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_write_reg;
    t_imm;
    t_abs;
    t_rind;
    t_mind;
    t_idx;
    t_ainc;
    t_adec;
    t_stalls;
    t_collide;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule